// File: doc/BRIEF.md
# FSK Frame Demodulator

This block turns a stream of one-bit sign samples of a low-frequency tag signal into framed, checked tag data. A sample is taken whenever the sample-valid strobe is high; the nominal rate is 2 MHz. The block counts rising zero crossings of the carrier. After every sixteenth crossing it measures how many samples that group of sixteen cycles took. A long group (slower carrier, about 123 kHz) is a logic 1. A short group (faster carrier, about 134 kHz) is a logic 0. A group that fits neither window is treated as noise and throws away everything collected so far.

Decoded bits arrive least significant first and go into a 128-bit register. After every new bit the register is tested for a frame. A frame has a run of seventeen zeros and then six ones, and it opens and closes with the same byte. When a frame is confirmed, the block pulses a found strobe. It also latches the 64-bit payload, the 16-bit check field, a rewritable flag, an identity-match flag and a CRC verdict. These outputs stay unchanged until the next confirmed frame.

Top module: `fskFrameDemod`

## Requirements
- R1: A cycle boundary is a valid sample of 1 whose previous valid sample was 0. The previous sample is taken as 1 out of reset, and samples with sampleValid low are ignored entirely. Every 16th boundary is a mark, and the measured count is the number of valid samples from the previous mark to this one. For example, a mark on sample index k after a mark on index j gives k-j.
- R2: A measured count from 249 to 269 inclusive yields a 1. A count from 228 to 248 inclusive yields a 0. These are the centres 259 and 238 with a half-window of 11 and strict bounds on both sides.
- R3: A measured count outside both windows (227 or less, 270 or more) clears all 128 register bits, and no bit is added.
- R4: The sample counter saturates at 1023, so a stalled input is measured as at least 1024 and handled as in R3. The count never wraps back into a window.
- R5: Each decoded bit enters register bit 127 while the register shifts right by one, so the first bit received ends up lowest.
- R6: After each new bit, a frame is confirmed when register bits [22:0] equal 0x7E0000 and bits [23:16] equal bits [111:104]. A confirmed frame raises frameFound for exactly one clock.
- R7: On confirmation, dataOut takes register bits [87:24] and crcOut takes bits [103:88].
- R8: rewritable takes register bit 111. identMatch is 1 only when rewritable is 1 and bits [126:112] equal dataOut bits [14:0]. Bit 127 takes no part in the comparison.
- R9: crcGood is 1 when crcOut equals a CRC-16 computed over dataOut. The CRC uses polynomial 0x1021 and starts from 0x0000. It takes data bit 0 first and then upward, which means least significant byte first with each byte least significant bit first. Each step computes feedback = crc[15] xor bit, shifts crc left by one, and XORs in the polynomial when the feedback is 1.
- R10: Out of reset all outputs are 0. Between confirmed frames, dataOut, crcOut, rewritable, identMatch and crcGood do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | A new sign sample is present this cycle |
| sampleBit | input | 1 | Sign of the sample, 1 = positive |
| frameFound | output | 1 | One-clock pulse on a confirmed frame |
| dataOut | output | 64 | Payload of the last confirmed frame |
| crcOut | output | 16 | Check field of the last confirmed frame |
| rewritable | output | 1 | Last frame came from a rewritable tag |
| identMatch | output | 1 | Rewritable tag identity agrees with the payload |
| crcGood | output | 1 | Check field agrees with the computed CRC |

## Verification
Corruption inside the bit register or the crossing counters stays invisible until the next frame boundary. It then shows up as a frame that goes missing or one that appears when it should not, up to 128 bit-times (roughly 30,000 samples) after the fault. The directed frames therefore place boundary-length groups, an out-of-window group and a stalled group at known bit positions, so that a wrong classification, a missing clear or a wrapping counter turns a found frame into a lost one or the reverse. Errors in the field slicing, the identity comparison or the CRC appear right away in the outputs latched with the found pulse, and payloads are chosen so that each flag is exercised in both states.

// File: rtl/fskDemodPkg.sv
package fskDemodPkg;

  // strobes from the crossing/measurement control into the bit datapath
  typedef struct packed {
    logic shiftEn;   // append bitVal to the register
    logic bitVal;    // decoded bit value
    logic clearReg;  // discard the whole register
  } demodStrobe_t;

endpackage

// File: rtl/fskCycleCtrl.sv
module fskCycleCtrl
  import fskDemodPkg::*;
#(
  parameter int unsigned SAMPLE_RATE    = 2000000,
  parameter int unsigned FREQ_LO        = 123200,
  parameter int unsigned FREQ_HI        = 134200,
  parameter int unsigned CYCLES_PER_BIT = 16,
  parameter int unsigned CNT_W          = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleValid,
  input  logic         sampleBit,
  output demodStrobe_t strobe
);

  localparam int unsigned CENTRE_LO = (SAMPLE_RATE * CYCLES_PER_BIT) / FREQ_LO;
  localparam int unsigned CENTRE_HI = (SAMPLE_RATE * CYCLES_PER_BIT) / FREQ_HI;
  localparam int unsigned HALF_WIN  = (CENTRE_LO - CENTRE_HI + 1) >> 1;
  localparam int unsigned CYC_W     = $clog2(CYCLES_PER_BIT);
  localparam int unsigned CNT_MAX   = (1 << CNT_W) - 1;

  logic             prevBit;
  logic [CYC_W-1:0] cycCnt;
  logic [CNT_W-1:0] sampCnt;
  logic [CNT_W:0]   measured;
  logic             rise, mark, inLo, inHi;

  assign rise     = sampleValid && sampleBit && !prevBit;
  assign mark     = rise && (cycCnt == CYC_W'(CYCLES_PER_BIT - 1));
  assign measured = {1'b0, sampCnt} + (CNT_W + 1)'(1);
  assign inLo     = (32'(measured) > (CENTRE_LO - HALF_WIN)) &&
                    (32'(measured) < (CENTRE_LO + HALF_WIN));
  assign inHi     = (32'(measured) > (CENTRE_HI - HALF_WIN)) &&
                    (32'(measured) < (CENTRE_HI + HALF_WIN));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevBit <= 1'b1;
      cycCnt  <= '0;
      sampCnt <= '0;
      strobe  <= '0;
    end else begin
      strobe <= '0;
      if (sampleValid) begin
        prevBit <= sampleBit;
        if (rise) cycCnt <= mark ? '0 : cycCnt + 1'b1;
        if (mark) begin
          sampCnt         <= '0;
          strobe.shiftEn  <= inLo || inHi;
          strobe.bitVal   <= inLo;
          strobe.clearReg <= !(inLo || inHi);
        end else if (sampCnt != CNT_W'(CNT_MAX)) begin
          sampCnt <= sampCnt + 1'b1;
        end
      end
    end
  end

  // R4: a stalled count stays pinned at its ceiling
  assert_count_saturates_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !mark && sampCnt == CNT_W'(CNT_MAX)) |=> sampCnt == CNT_W'(CNT_MAX));

  // R1: every decision follows a valid positive sample
  assert_strobe_after_rise_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftEn || strobe.clearReg) |-> $past(sampleValid && sampleBit));

endmodule

// File: rtl/fskFrameDatapath.sv
module fskFrameDatapath
  import fskDemodPkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned CRC_W    = 16,
  parameter logic [15:0] CRC_POLY = 16'h1021,
  parameter int unsigned ZERO_RUN = 17,
  parameter int unsigned ONE_RUN  = 6,
  parameter int unsigned IDENT_W  = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  demodStrobe_t      strobe,
  output logic              frameFound,
  output logic [DATA_W-1:0] dataOut,
  output logic [CRC_W-1:0]  crcOut,
  output logic              rewritable,
  output logic              identMatch,
  output logic              crcGood
);

  localparam int unsigned MARK_W    = 8;
  localparam int unsigned SYNC_W    = ZERO_RUN + ONE_RUN;
  localparam int unsigned START_LSB = SYNC_W + 1 - MARK_W;
  localparam int unsigned DATA_LSB  = SYNC_W + 1;
  localparam int unsigned CRC_LSB   = DATA_LSB + DATA_W;
  localparam int unsigned END_LSB   = CRC_LSB + CRC_W;
  localparam int unsigned RW_BIT    = END_LSB + MARK_W - 1;
  localparam int unsigned IDENT_LSB = END_LSB + MARK_W;
  localparam int unsigned FRAME_W   = IDENT_LSB + IDENT_W + 1;
  localparam logic [SYNC_W-1:0] SYNC_PAT = SYNC_W'(((64'd1 << ONE_RUN) - 1) << ZERO_RUN);

  logic [FRAME_W-1:0] shiftReg;
  logic               shiftedQ;
  logic               syncHit, endHit;
  logic [DATA_W-1:0]  dataField;
  logic [CRC_W-1:0]   crcField, crcCalc;

  function automatic logic [CRC_W-1:0] crcOver(input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = '0;
    for (int i = 0; i < DATA_W; i++) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_W'(CRC_POLY);
    end
    return c;
  endfunction

  assign dataField = shiftReg[CRC_LSB-1:DATA_LSB];
  assign crcField  = shiftReg[END_LSB-1:CRC_LSB];
  assign crcCalc   = crcOver(dataField);
  assign syncHit   = (shiftReg[SYNC_W-1:0] == SYNC_PAT);
  assign endHit    = (shiftReg[START_LSB+MARK_W-1:START_LSB] ==
                      shiftReg[END_LSB+MARK_W-1:END_LSB]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      shiftedQ <= 1'b0;
    end else begin
      shiftedQ <= strobe.shiftEn;
      if (strobe.clearReg)     shiftReg <= '0;
      else if (strobe.shiftEn) shiftReg <= {strobe.bitVal, shiftReg[FRAME_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameFound <= 1'b0;
      dataOut    <= '0;
      crcOut     <= '0;
      rewritable <= 1'b0;
      identMatch <= 1'b0;
      crcGood    <= 1'b0;
    end else begin
      frameFound <= 1'b0;
      if (shiftedQ && syncHit && endHit) begin
        frameFound <= 1'b1;
        dataOut    <= dataField;
        crcOut     <= crcField;
        rewritable <= shiftReg[RW_BIT];
        identMatch <= shiftReg[RW_BIT] &&
                      (shiftReg[IDENT_LSB+IDENT_W-1:IDENT_LSB] == dataField[IDENT_W-1:0]);
        crcGood    <= (crcCalc == crcField);
      end
    end
  end

  // R3: an out-of-window decision empties the register
  assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearReg |=> shiftReg == '0);

  // R5: new bit lands on top, the rest move down one place
  assert_shift_right_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftEn && !strobe.clearReg) |=>
      shiftReg == {$past(strobe.bitVal), $past(shiftReg[FRAME_W-1:1])});

  // R6: found strobe never lasts two clocks
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    frameFound |=> !frameFound);

  // R8: identity agreement only reported for rewritable tags
  assert_ident_needs_rw_R8: assert property (@(posedge clk) disable iff (!rstN)
    identMatch |-> rewritable);

  // R10: latched fields only move together with a found pulse
  assert_fields_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !frameFound |-> ($stable(dataOut) && $stable(crcOut) && $stable(crcGood)));

endmodule

// File: rtl/fskFrameDemod.sv
module fskFrameDemod
  import fskDemodPkg::*;
#(
  parameter int unsigned SAMPLE_RATE    = 2000000,
  parameter int unsigned FREQ_LO        = 123200,
  parameter int unsigned FREQ_HI        = 134200,
  parameter int unsigned CYCLES_PER_BIT = 16,
  parameter int unsigned CNT_W          = 10,
  parameter int unsigned DATA_W         = 64,
  parameter int unsigned CRC_W          = 16,
  parameter logic [15:0] CRC_POLY       = 16'h1021
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              sampleBit,
  output logic              frameFound,
  output logic [DATA_W-1:0] dataOut,
  output logic [CRC_W-1:0]  crcOut,
  output logic              rewritable,
  output logic              identMatch,
  output logic              crcGood
);

  demodStrobe_t strobe;

  fskCycleCtrl #(
    .SAMPLE_RATE(SAMPLE_RATE), .FREQ_LO(FREQ_LO), .FREQ_HI(FREQ_HI),
    .CYCLES_PER_BIT(CYCLES_PER_BIT), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sampleBit(sampleBit), .strobe(strobe)
  );

  fskFrameDatapath #(
    .DATA_W(DATA_W), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .frameFound(frameFound),
    .dataOut(dataOut), .crcOut(crcOut), .rewritable(rewritable),
    .identMatch(identMatch), .crcGood(crcGood)
  );

endmodule

// File: tb/fskFrameDemod_tb_top.sv
module fskFrameDemod_tb_top;

  logic        clk = 1'b0;
  logic        rstN, sampleValid, sampleBit;
  logic        frameFound, rewritable, identMatch, crcGood;
  logic [63:0] dataOut;
  logic [15:0] crcOut;

  always #2 clk = ~clk;

  fskFrameDemod dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleBit(sampleBit),
    .frameFound(frameFound), .dataOut(dataOut), .crcOut(crcOut),
    .rewritable(rewritable), .identMatch(identMatch), .crcGood(crcGood)
  );

  int checks = 0, fails = 0;
  int pulseCnt = 0, widePulse = 0, holdErr = 0, sampleIdx = 0;
  logic        prevFound = 1'b0;
  logic [82:0] lastVals = '0;

  // monitor away from the active edge
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      if (frameFound) pulseCnt++;
      if (frameFound && prevFound) widePulse++;
      if (!frameFound && lastVals != {dataOut, crcOut, rewritable, identMatch, crcGood})
        holdErr++;
    end
    prevFound = frameFound;
    lastVals  = {dataOut, crcOut, rewritable, identMatch, crcGood};
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crcRef(input logic [63:0] d);
    logic [15:0] c = 16'h0000;
    logic fb;
    for (int i = 0; i < 64; i++) begin
      fb = c[15] ^ d[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [127:0] mkFrame(input logic [63:0] d, input logic [15:0] c,
                                           input logic rw, input logic [14:0] id,
                                           input logic top);
    logic [127:0] f = '0;
    f[22:17]   = 6'h3F;
    f[23]      = rw;
    f[87:24]   = d;
    f[103:88]  = c;
    f[111:104] = {rw, 7'b1111110};
    f[126:112] = id;
    f[127]     = top;
    return f;
  endfunction

  task automatic putSample(input logic b);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleBit   = b;
    sampleIdx++;
    if (sampleIdx % 64 == 0) begin
      @(negedge clk);
      sampleValid = 1'b0;
      sampleBit   = ~b;   // must be ignored
    end
  endtask

  // 16 carrier cycles spanning n valid samples, first crossing at its start
  task automatic sendBlock(input int n);
    for (int c = 0; c < 16; c++) begin
      int len = n / 16 + ((c < n % 16) ? 1 : 0);
      for (int k = 0; k < len; k++) putSample(k < len / 2);
    end
  endtask

  task automatic sendBits(input logic [127:0] f, input int lo, input int hi,
                          input int oneLen, input int zeroLen);
    for (int i = lo; i <= hi; i++) sendBlock(f[i] ? oneLen : zeroLen);
  endtask

  task automatic expectFrame(input string tag, input logic [63:0] d, input logic [15:0] c,
                             input logic rw, input logic im, input logic cg);
    chk(pulseCnt == 1, "R6", {tag, " pulse count"}, 64'(pulseCnt), 64'd1);
    chk(dataOut == d, "R7", {tag, " data"}, dataOut, d);
    chk(crcOut == c, "R7", {tag, " crc field"}, 64'(crcOut), 64'(c));
    chk(rewritable == rw, "R8", {tag, " rewritable"}, 64'(rewritable), 64'(rw));
    chk(identMatch == im, "R8", {tag, " identMatch"}, 64'(identMatch), 64'(im));
    chk(crcGood == cg, "R9", {tag, " crcGood"}, 64'(crcGood), 64'(cg));
  endtask

  task automatic testReset();
    chk(frameFound == 1'b0, "R10", "reset frameFound", 64'(frameFound), 64'd0);
    chk(dataOut == 64'd0 && crcOut == 16'd0, "R10", "reset fields",
        dataOut ^ 64'(crcOut), 64'd0);
    chk({rewritable, identMatch, crcGood} == 3'b000, "R10", "reset flags",
        64'({rewritable, identMatch, crcGood}), 64'd0);
  endtask

  // R2 edges 248 (zero) and 249 (one); read-only tag with valid CRC
  task automatic testReadOnly();
    logic [63:0]  d = 64'h0123_4567_89AB_CDEF;
    logic [127:0] f = mkFrame(d, crcRef(d), 1'b0, d[14:0], 1'b0);
    pulseCnt = 0;
    sendBlock(100);
    sendBits(f, 0, 127, 249, 248);
    sendBlock(100);
    expectFrame("R2 readonly", d, crcRef(d), 1'b0, 1'b0, 1'b1);
  endtask

  // R8 bit 127 excluded; R9 bad CRC reported
  task automatic testRwBadCrc();
    logic [63:0]  d = 64'hFEDC_BA98_7654_3210;
    logic [15:0]  c = crcRef(d) ^ 16'h0001;
    logic [127:0] f = mkFrame(d, c, 1'b1, d[14:0], ~d[15]);
    pulseCnt = 0;
    sendBlock(100);
    sendBits(f, 0, 127, 249, 228);
    sendBlock(100);
    expectFrame("R8 rw bad crc", d, c, 1'b1, 1'b1, 1'b0);
  endtask

  // R8 ident mismatch; R2 edges 269 (one) and 228 (zero)
  task automatic testRwMismatch();
    logic [63:0]  d = 64'hA5A5_5A5A_0F0F_C3C3;
    logic [127:0] f = mkFrame(d, crcRef(d), 1'b1, d[14:0] ^ 15'h0001, 1'b0);
    pulseCnt = 0;
    sendBlock(100);
    sendBits(f, 0, 127, 269, 228);
    sendBlock(100);
    expectFrame("R8 rw mismatch", d, crcRef(d), 1'b1, 1'b0, 1'b1);
  endtask

  // R3: a 270-sample group between bit 63 and bit 64 must clear
  task automatic testClear();
    logic [63:0]  d = 64'h0123_4567_89AB_CDEF;
    logic [127:0] f = mkFrame(d, crcRef(d), 1'b0, 15'h0, 1'b0);
    logic [63:0]  keep = dataOut;
    pulseCnt = 0;
    sendBlock(100);
    sendBits(f, 0, 63, 249, 228);
    sendBlock(270);
    sendBits(f, 64, 127, 249, 228);
    sendBlock(100);
    chk(pulseCnt == 0, "R3", "no frame after clear", 64'(pulseCnt), 64'd0);
    chk(dataOut == keep, "R10", "fields kept without frame", dataOut, keep);
  endtask

  // R4: a stalled group in place of bit 64 (a one) must not wrap into the window
  task automatic testStall();
    logic [63:0]  d = 64'h0123_4567_89AB_CDEF;   // bit 40 -> frame bit 64 is 1
    logic [127:0] f = mkFrame(d, crcRef(d), 1'b0, 15'h0, 1'b0);
    pulseCnt = 0;
    sendBlock(100);
    sendBits(f, 0, 63, 249, 228);
    sendBlock(1283);
    sendBits(f, 65, 127, 249, 228);
    sendBlock(100);
    chk(pulseCnt == 0, "R4", "stall treated as invalid", 64'(pulseCnt), 64'd0);
  endtask

  // R6: start and end bytes differ
  task automatic testEndMismatch();
    logic [63:0]  d = 64'h1122_3344_5566_7788;
    logic [127:0] f = mkFrame(d, crcRef(d), 1'b0, 15'h0, 1'b0);
    f[105] = ~f[105];
    pulseCnt = 0;
    sendBlock(100);
    sendBits(f, 0, 127, 249, 228);
    sendBlock(100);
    chk(pulseCnt == 0, "R6", "end byte mismatch rejected", 64'(pulseCnt), 64'd0);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    sampleValid = 1'b0;
    sampleBit = 1'b0;
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    // prime: one low sample, then 15 crossings so the next block opens on a mark (R1)
    putSample(1'b0);
    for (int c = 0; c < 15; c++)
      for (int k = 0; k < 16; k++) putSample(k < 8);
    testReadOnly();
    testRwBadCrc();
    testRwMismatch();
    testClear();
    testStall();
    testEndMismatch();
    @(negedge clk);
    sampleValid = 1'b0;
    repeat (4) @(negedge clk);
    chk(widePulse == 0, "R6", "pulse width one clock", 64'(widePulse), 64'd0);
    chk(holdErr == 0, "R10", "fields held between frames", 64'(holdErr), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule